// File: doc/BRIEF.md
# Serial Memory Deep-Sleep Wake Controller

This block is the device-side logic of a serial memory that takes the part out of its deepest low-power state. A one-cycle request on a system-clock input parks the block in that state. Leaving it takes one exact command. With the select line held low, the host shifts in a single byte of value 0xAB, most significant bit first. Then it releases the select line. No address or dummy bytes follow the command.

On that release, the block starts a recovery interval of a parameterised number of system clock cycles. During the interval the ready flag stays low. That flag gates every other command decoder of the memory. If the host pulls select low again before the interval ends, the frame is thrown away and a one-cycle protocol-error pulse is raised. The recovery count does not restart.

All three serial pins come into the system clock domain through synchronizers of at least two stages. Serial data is taken on the rising edge of the serial clock as seen after synchronization.

Top module: `dpdw_wake_ctrl`

## Requirements
- R1: After reset, `pwr_state` is 2'b00 (standby), `cmd_ready` is 1 and `proto_err` is 0.
- R2: A high `sleep_req` sampled at a clock edge while in standby sets `pwr_state` to 2'b01 (deep) from that edge, and `cmd_ready` drops to 0.
- R3: `sleep_req` has no effect while `pwr_state` is 2'b01 (deep) or 2'b10 (recovering).
- R4: Bits are taken on rising `sck` edges while `cs_n` is low, first bit as the most significant. A frame of exactly 8 bits equal to 0xAB, closed by `cs_n` rising, moves the block from deep to recovering.
- R5: In deep, a closed 8-bit frame holding any other value leaves the block in deep. This includes 0xD5, which is 0xAB sent least significant bit first.
- R6: In deep, a frame of 7 or of 9 bits leaves the block in deep, even when its first 8 bits are 0xAB.
- R7: The block does not leave deep while `cs_n` stays low after the eighth bit. Only the rising edge of `cs_n` ends the frame.
- R8: With `cs_n` raised between clock edges, `pwr_state` is 2'b10 and `cmd_ready` is 0 through the (RECOVER_CYC+2)th following edge. At the (RECOVER_CYC+3)th edge, `pwr_state` returns to 2'b00 and `cmd_ready` to 1.
- R9: A `cs_n` fall during recovery gives a one-cycle `proto_err` pulse at the third clock edge after the fall. The end of recovery keeps the timing of R8.
- R10: `proto_err` stays 0 for select activity while in deep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | One-cycle strobe that enters the deep state |
| cs_n | input | 1 | Serial chip select, active low, asynchronous |
| sck | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data in, asynchronous |
| pwr_state | output | 2 | 00 standby, 01 deep, 10 recovering |
| cmd_ready | output | 1 | High when other commands may be decoded |
| proto_err | output | 1 | One-cycle pulse when select falls during recovery |

## Verification
The embedded properties assume that each serial pin level lasts several system clock cycles. Under that assumption, every `sck` rise and every `cs_n` edge shows up as exactly one event after synchronization. They also assume that `sdi` is steady across the synchronized `sck` rise. The bench drives each half period of `sck` as four system clocks and sets `sdi` four clocks before the rising edge. It opens and closes `cs_n` four clocks away from any `sck` change, and it changes every input only on the falling system clock edge.

// File: rtl/dpdw_pkg.sv
package dpdw_pkg;
   typedef enum logic [1:0] {
      PW_STANDBY = 2'b00,
      PW_DEEP    = 2'b01,
      PW_RECOVER = 2'b10
   } pwr_e;
endpackage

// File: rtl/dpdw_sync.sv
module dpdw_sync #(
   parameter int          WIDTH   = 3,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dpdw_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg[g] <= RST_VAL;
         end else begin
            stg[g] <= (g == 0) ? d_async : stg[(g == 0) ? 0 : g-1];
         end
      end
   end

   assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/dpdw_shifter.sv
module dpdw_shifter #(
   parameter int                 OPC_BITS = 8,
   parameter logic [OPC_BITS-1:0] WAKE_OPC = 8'hAB
) (
   input  logic clk,
   input  logic rst_n,
   input  logic csn_s,
   input  logic sck_s,
   input  logic sdi_s,
   output logic sel_fall,
   output logic sel_rise,
   output logic frame_wake
);
   localparam int CNT_MAX = OPC_BITS + 1;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   if (OPC_BITS < 1) begin : g_bad_bits
      $error("dpdw_shifter: OPC_BITS must be positive");
   end

   logic                csn_q;
   logic                sck_q;
   logic                sck_rise;
   logic [OPC_BITS-1:0] shreg;
   logic [CNT_W-1:0]    bit_cnt;

   assign sel_fall = csn_q & ~csn_s;
   assign sel_rise = ~csn_q & csn_s;
   assign sck_rise = ~sck_q & sck_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         csn_q <= 1'b1;
         sck_q <= 1'b0;
      end else begin
         csn_q <= csn_s;
         sck_q <= sck_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg   <= '0;
         bit_cnt <= '0;
      end else if (sel_fall) begin
         bit_cnt <= '0;
      end else if (!csn_s && sck_rise) begin
         shreg <= {shreg[OPC_BITS-2:0], sdi_s};
         if (bit_cnt != CNT_W'(CNT_MAX)) begin
            bit_cnt <= bit_cnt + 1'b1;
         end
      end
   end

   assign frame_wake = sel_rise && (bit_cnt == CNT_W'(OPC_BITS)) && (shreg == WAKE_OPC);

   // R6: bit counter saturates just past a full opcode
   p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(CNT_MAX));
endmodule

// File: rtl/dpdw_rec_timer.sv
module dpdw_rec_timer #(
   parameter int RECOVER_CYC = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic run,
   output logic done
);
   localparam int TW = (RECOVER_CYC > 1) ? $clog2(RECOVER_CYC) : 1;

   if (RECOVER_CYC < 1) begin : g_bad_cyc
      $error("dpdw_rec_timer: RECOVER_CYC must be at least 1");
   end

   if (RECOVER_CYC == 1) begin : g_single
      assign done = run;
   end else begin : g_count
      logic [TW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt <= '0;
         end else if (start) begin
            cnt <= '0;
         end else if (run && !done) begin
            cnt <= cnt + 1'b1;
         end
      end
      assign done = run && (cnt == TW'(RECOVER_CYC - 1));

      // R8: the count never passes the last recovery cycle
      p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
         run |-> (cnt <= TW'(RECOVER_CYC - 1)));
   end
endmodule

// File: rtl/dpdw_wake_ctrl.sv
module dpdw_wake_ctrl
   import dpdw_pkg::*;
#(
   parameter int                 OPC_BITS    = 8,
   parameter logic [OPC_BITS-1:0] WAKE_OPC   = 8'hAB,
   parameter int                 RECOVER_CYC = 40,
   parameter int                 SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sleep_req,
   input  logic       cs_n,
   input  logic       sck,
   input  logic       sdi,
   output logic [1:0] pwr_state,
   output logic       cmd_ready,
   output logic       proto_err
);
   localparam logic [2:0] PIN_RST = 3'b100;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dpdw_wake_ctrl: SYNC_STAGES must be at least 2");
   end

   logic [2:0] pins_s;
   logic       sel_fall;
   logic       sel_rise;
   logic       frame_wake;
   logic       tmr_start;
   logic       tmr_done;
   pwr_e       state, state_nx;

   dpdw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async ({cs_n, sck, sdi}),
      .q_sync  (pins_s)
   );

   dpdw_shifter #(.OPC_BITS(OPC_BITS), .WAKE_OPC(WAKE_OPC)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .csn_s      (pins_s[2]),
      .sck_s      (pins_s[1]),
      .sdi_s      (pins_s[0]),
      .sel_fall   (sel_fall),
      .sel_rise   (sel_rise),
      .frame_wake (frame_wake)
   );

   dpdw_rec_timer #(.RECOVER_CYC(RECOVER_CYC)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (tmr_start),
      .run   (state == PW_RECOVER),
      .done  (tmr_done)
   );

   always_comb begin
      state_nx  = state;
      tmr_start = 1'b0;
      unique case (state)
         PW_STANDBY: if (sleep_req) state_nx = PW_DEEP;
         PW_DEEP: begin
            if (frame_wake) begin
               state_nx  = PW_RECOVER;
               tmr_start = 1'b1;
            end
         end
         PW_RECOVER: if (tmr_done) state_nx = PW_STANDBY;
         default: state_nx = PW_STANDBY;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= PW_STANDBY;
         proto_err <= 1'b0;
      end else begin
         state     <= state_nx;
         proto_err <= (state == PW_RECOVER) && sel_fall;
      end
   end

   assign pwr_state = state;
   assign cmd_ready = (state == PW_STANDBY);

   // R5: deep is left only through a complete wake frame
   p_deep_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PW_DEEP && !frame_wake) |=> (state == PW_DEEP));
   // R8: lockout held until the timer expires
   p_lockout_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PW_RECOVER && !tmr_done) |=> (state == PW_RECOVER && !cmd_ready));
   // R8: ready returns only after an expired timer
   p_ready_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_ready) |-> $past(tmr_done));
   // R9: error is a single-cycle pulse
   p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> !proto_err);
   // R10: error only arises out of recovery
   p_err_ctx_r10: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |-> ($past(state) == PW_RECOVER));
endmodule

// File: tb/tb_dpdw_wake_ctrl.sv
module tb_dpdw_wake_ctrl;
   localparam int REC = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sleep_req = 1'b0;
   logic       cs_n = 1'b1;
   logic       sck = 1'b0;
   logic       sdi = 1'b0;
   logic [1:0] pwr_state;
   logic       cmd_ready;
   logic       proto_err;

   int checks = 0;
   int errors = 0;
   logic err_seen = 1'b0;

   always #2 clk = ~clk;

   dpdw_wake_ctrl #(.RECOVER_CYC(REC)) dut (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .cs_n(cs_n),
      .sck(sck), .sdi(sdi), .pwr_state(pwr_state), .cmd_ready(cmd_ready),
      .proto_err(proto_err)
   );

   always @(posedge clk) if (proto_err) err_seen <= 1'b1;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic send_bits(input logic [15:0] v, input int n);
      cs_n = 1'b0;
      tick(4);
      for (int i = n - 1; i >= 0; i--) begin
         sdi = v[i];
         tick(4);
         sck = 1'b1;
         tick(4);
         sck = 1'b0;
      end
      tick(4);
   endtask

   task automatic go_deep();
      sleep_req = 1'b1;
      tick(1);
      sleep_req = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 pwr_state", pwr_state, 2'b00);
      check("R1 cmd_ready", cmd_ready, 1'b1);
      check("R1 proto_err", proto_err, 1'b0);
   endtask

   task automatic t_sleep();
      go_deep();
      check("R2 pwr_state", pwr_state, 2'b01);
      check("R2 cmd_ready", cmd_ready, 1'b0);
      go_deep();
      tick(2);
      check("R3 sleep in deep", pwr_state, 2'b01);
   endtask

   task automatic t_bad_frames();
      err_seen = 1'b0;
      send_bits(16'h00AA, 8); cs_n = 1'b1; tick(10);
      check("R5 byte AA", pwr_state, 2'b01);
      send_bits(16'h00D5, 8); cs_n = 1'b1; tick(10);
      check("R5 LSB-first AB", pwr_state, 2'b01);
      send_bits(16'h0055, 7); cs_n = 1'b1; tick(10);
      check("R6 seven bits", pwr_state, 2'b01);
      send_bits(16'h0157, 9); cs_n = 1'b1; tick(10);
      check("R6 nine bits", pwr_state, 2'b01);
      check("R10 no error in deep", err_seen, 1'b0);
   endtask

   task automatic t_wake_ok();
      send_bits(16'h00AB, 8);
      tick(20);
      check("R7 held low", pwr_state, 2'b01);
      check("R7 ready low", cmd_ready, 1'b0);
      cs_n = 1'b1;
      tick(5);
      check("R4 entered recovery", pwr_state, 2'b10);
      sleep_req = 1'b1;
      tick(1);
      sleep_req = 1'b0;
      check("R3 sleep in recovery", pwr_state, 2'b10);
      tick(REC + 2 - 6);
      check("R8 still recovering", pwr_state, 2'b10);
      check("R8 ready low", cmd_ready, 1'b0);
      tick(1);
      check("R8 standby", pwr_state, 2'b00);
      check("R8 ready high", cmd_ready, 1'b1);
   endtask

   task automatic t_err();
      go_deep();
      send_bits(16'h00AB, 8);
      cs_n = 1'b1;
      tick(6);
      cs_n = 1'b0;
      tick(2);
      check("R9 no pulse yet", proto_err, 1'b0);
      tick(1);
      check("R9 pulse", proto_err, 1'b1);
      tick(1);
      check("R9 pulse ends", proto_err, 1'b0);
      cs_n = 1'b1;
      tick(REC + 2 - 10);
      check("R9 timer kept", pwr_state, 2'b10);
      tick(1);
      check("R9 ready on time", cmd_ready, 1'b1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(2);
      t_reset();
      t_sleep();
      t_bad_frames();
      t_wake_ok();
      t_err();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule